// File: doc/BRIEF.md
# Comparator Change-Detect Interrupt

This block turns changes of a comparator's digital output into a sticky, software-visible interrupt flag. Two single-bit holding registers follow the comparator. The reference register takes a fresh copy of the output whenever the host accesses the comparator control register, either by reading it or by writing it. The sample register copies the output once per instruction cycle. When the two registers disagree, a mismatch exists. The rising edge of that mismatch sets the flag. The level of the mismatch does not set the flag.

Each instruction cycle has four system-clock phases, counted by a free-running phase counter that reset starts at the first phase. The comparator is sampled in the first phase. Host accesses take effect only in the second phase. Software clears the flag by writing 0 to it and may force it by writing 1. The interrupt request is the flag gated by three enables: a local comparator enable, a peripheral enable and a global enable. Because a control-register access refreshes the reference, it decides whether a later return to the old level raises a second interrupt.

Top module: `cmp_change_irq`

## Requirements
- R1: After a synchronous reset (rstN low), cmpFlag and irqReq are 0, and both holding registers equal the comparator level present during reset, so holding that level afterwards never sets the flag.
- R2: Phases repeat in a 4-clock cycle that starts with phase 1 on the first clock edge after reset release. The comparator is sampled on the phase-1 edge only. ctrlRead, ctrlWrite and flagWrite act on the phase-2 edge only and are ignored on the other three edges.
- R3: A comparator change with no control-register access sets cmpFlag by the end of the instruction cycle in which the new level is sampled.
- R4: Once cmpFlag is cleared, a mismatch that persists does not set it again.
- R5: If the output returns to the reference level without an intervening access, the mismatch disappears and cmpFlag is not set.
- R6: If a read refreshed the reference after a change, a later return to the earlier level sets cmpFlag.
- R7: A control-register write refreshes the reference exactly like a read.
- R8: A flag write with flagWdata=0 clears cmpFlag and one with flagWdata=1 sets it. A mismatch edge in the same cycle as a clearing write leaves the flag set.
- R9: irqReq is 1 exactly when cmpFlag, cmpIe, periphIe and globalIe are all 1. cmpFlag still sets when any enable is 0.
- R10: If a control-register access falls in the same phase-2 cycle as a mismatch edge, the reference update wins and cmpFlag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (four per instruction cycle) |
| rstN | input | 1 | Synchronous active-low reset |
| cmpOut | input | 1 | Synchronized comparator output |
| ctrlRead | input | 1 | Control-register read strobe |
| ctrlWrite | input | 1 | Control-register write strobe |
| flagWrite | input | 1 | Write strobe for the interrupt flag |
| flagWdata | input | 1 | Value written to the flag |
| cmpIe | input | 1 | Local comparator interrupt enable |
| periphIe | input | 1 | Peripheral interrupt enable |
| globalIe | input | 1 | Global interrupt enable |
| cmpFlag | output | 1 | Sticky change-detect flag |
| irqReq | output | 1 | Gated interrupt request |

## Verification
Directed instruction-cycle sequences cover a single change, a persistent change after the flag is cleared, a return with and without an intervening read or write, and accesses placed in every phase other than the second. These sequences separate edge detection from level detection, and they separate a read-referenced mismatch from an output edge. Collisions are also driven: a mismatch edge meeting a clearing flag write, and a mismatch edge meeting a read. The interrupt gate is swept over all eight enable combinations, with the flag set and with the flag clear. A long pseudo-random run then mixes changes, accesses, flag writes and enable patterns. On every clock, that run is compared against an arithmetic model of the phase-by-phase rules.

// File: rtl/cmpirq_pkg.sv
package cmpirq_pkg;
  // Per-clock strobes issued by the phase control to the datapath
  typedef struct packed {
    logic sampleEn;  // copy comparator into the sample register
    logic refLoad;   // control-register access: refresh the reference
    logic flagWr;    // software write to the flag
  } cmpirq_strobe_t;
endpackage

// File: rtl/cmpirq_ctrl.sv
module cmpirq_ctrl
  import cmpirq_pkg::*;
#(
  parameter int NUM_PHASES   = 4,
  parameter int SAMPLE_PHASE = 0,
  parameter int ACCESS_PHASE = 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           ctrlRead,
  input  logic           ctrlWrite,
  input  logic           flagWrite,
  output cmpirq_strobe_t strb
);
  localparam int PW = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1;
  localparam logic [PW-1:0] LAST_PH   = PW'(NUM_PHASES - 1);
  localparam logic [PW-1:0] SAMPLE_PH = PW'(SAMPLE_PHASE);
  localparam logic [PW-1:0] ACCESS_PH = PW'(ACCESS_PHASE);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rstN)                phase <= '0;
    else if (phase == LAST_PH) phase <= '0;
    else                      phase <= phase + PW'(1);
  end

  logic inAccess;
  always_comb begin
    inAccess      = (phase == ACCESS_PH);
    strb.sampleEn = (phase == SAMPLE_PH);
    strb.refLoad  = inAccess & (ctrlRead | ctrlWrite);
    strb.flagWr   = inAccess & flagWrite;
  end

  // R2: the phase count wraps back to the first phase
  assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == LAST_PH) |=> (phase == '0));

  // R2: at most one access slot per instruction cycle
  assert_single_access_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.refLoad |=> !strb.refLoad);
endmodule

// File: rtl/cmpirq_datapath.sv
module cmpirq_datapath
  import cmpirq_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           cmpOut,
  input  logic           flagWdata,
  input  cmpirq_strobe_t strb,
  input  logic           cmpIe,
  input  logic           periphIe,
  input  logic           globalIe,
  output logic           cmpFlag,
  output logic           irqReq
);
  logic sampLatch;   // once-per-cycle copy of comparator
  logic refLatch;    // copy taken at each control-register access
  logic mismPrev;    // mismatch delayed one clock for edge detection
  logic flagQ;

  logic mismatch, mismRise, hwSet;
  always_comb begin
    mismatch = refLatch ^ sampLatch;
    mismRise = mismatch & ~mismPrev;
    hwSet    = mismRise & ~strb.refLoad;  // access in the same slot wins
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampLatch <= cmpOut;
      refLatch  <= cmpOut;
      mismPrev  <= 1'b0;
      flagQ     <= 1'b0;
    end else begin
      if (strb.sampleEn) sampLatch <= cmpOut;
      if (strb.refLoad)  refLatch  <= cmpOut;
      mismPrev <= mismatch;
      if (hwSet)            flagQ <= 1'b1;
      else if (strb.flagWr) flagQ <= flagWdata;
    end
  end

  always_comb begin
    cmpFlag = flagQ;
    irqReq  = flagQ & cmpIe & periphIe & globalIe;
  end

  // R2: sample register only moves on the sampling slot
  assert_sample_slot_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$stable(sampLatch)) |-> $past(strb.sampleEn));

  // R7: reference only moves on an access (read or write)
  assert_ref_on_access_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$stable(refLatch)) |-> $past(strb.refLoad));

  // R3: flag rises only from a mismatch edge or a software set
  assert_flag_rise_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $rose(flagQ)) |->
      ($past(mismRise) || ($past(strb.flagWr) && $past(flagWdata))));

  // R8: flag falls only through a software write of zero
  assert_flag_clear_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $fell(flagQ)) |-> ($past(strb.flagWr) && !$past(flagWdata)));

  // R10: a mismatch edge colliding with an access does not set the flag
  assert_race_no_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    (mismRise && strb.refLoad && !(strb.flagWr && flagWdata) && !flagQ)
      |=> !flagQ);

  // R9: a request never appears without the flag and the global enable
  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (cmpFlag && globalIe));
endmodule

// File: rtl/cmp_change_irq.sv
module cmp_change_irq
  import cmpirq_pkg::*;
#(
  parameter int NUM_PHASES   = 4,
  parameter int SAMPLE_PHASE = 0,
  parameter int ACCESS_PHASE = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmpOut,
  input  logic ctrlRead,
  input  logic ctrlWrite,
  input  logic flagWrite,
  input  logic flagWdata,
  input  logic cmpIe,
  input  logic periphIe,
  input  logic globalIe,
  output logic cmpFlag,
  output logic irqReq
);
  cmpirq_strobe_t strb;

  cmpirq_ctrl #(
    .NUM_PHASES  (NUM_PHASES),
    .SAMPLE_PHASE(SAMPLE_PHASE),
    .ACCESS_PHASE(ACCESS_PHASE)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlRead (ctrlRead),
    .ctrlWrite(ctrlWrite),
    .flagWrite(flagWrite),
    .strb     (strb)
  );

  cmpirq_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmpOut   (cmpOut),
    .flagWdata(flagWdata),
    .strb     (strb),
    .cmpIe    (cmpIe),
    .periphIe (periphIe),
    .globalIe (globalIe),
    .cmpFlag  (cmpFlag),
    .irqReq   (irqReq)
  );
endmodule

// File: tb/cmp_change_irq_bench.sv
`timescale 1ns/1ps
module cmp_change_irq_bench;
  logic clk = 1'b0;
  logic rstN, cmpOut, ctrlRead, ctrlWrite, flagWrite, flagWdata;
  logic cmpIe, periphIe, globalIe;
  logic cmpFlag, irqReq;

  always #2.5 clk = ~clk;

  cmp_change_irq u_cmp_change_irq (
    .clk(clk), .rstN(rstN), .cmpOut(cmpOut), .ctrlRead(ctrlRead),
    .ctrlWrite(ctrlWrite), .flagWrite(flagWrite), .flagWdata(flagWdata),
    .cmpIe(cmpIe), .periphIe(periphIe), .globalIe(globalIe),
    .cmpFlag(cmpFlag), .irqReq(irqReq));

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit sweepOn = 0;

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Arithmetic model of the phase rules (4 phases, sample in 0, access in 1)
  int   mPh;
  logic mRef, mSamp, mPrev, mFlag;
  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mRef = cmpOut; mSamp = cmpOut; mPrev = 0; mFlag = 0;
    end else begin
      logic mis, acc, fw, setIt;
      mis   = mRef ^ mSamp;
      acc   = (mPh == 1) && (ctrlRead || ctrlWrite);
      fw    = (mPh == 1) && flagWrite;
      setIt = mis && !mPrev && !acc;
      if (setIt)   mFlag = 1'b1;
      else if (fw) mFlag = flagWdata;
      if (mPh == 0) mSamp = cmpOut;
      if (acc)      mRef  = cmpOut;
      mPrev = mis;
      mPh   = (mPh + 1) % 4;
    end
  end

  // One instruction cycle: masks select the phases in which each strobe is high
  task automatic icyc(input logic c, input logic [3:0] rdM, input logic [3:0] wrM,
                      input logic [3:0] fwM, input logic fwd);
    for (int p = 0; p < 4; p++) begin
      cmpOut = c; ctrlRead = rdM[p]; ctrlWrite = wrM[p];
      flagWrite = fwM[p]; flagWdata = fwd;
      @(negedge clk);
    end
    ctrlRead = 0; ctrlWrite = 0; flagWrite = 0;
  endtask

  function automatic logic [15:0] lfsrNext(input logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    rstN = 0; cmpOut = 1; ctrlRead = 0; ctrlWrite = 0; flagWrite = 0; flagWdata = 0;
    cmpIe = 0; periphIe = 0; globalIe = 0;
    repeat (6) @(negedge clk);
    chk("R1 flag in reset", cmpFlag, 1'b0);
    rstN = 1;
    chk("R1 irq after reset", irqReq, 1'b0);
    icyc(1, 4'b0000, 4'b0000, 4'b0000, 0);
    chk("R1 reset level held", cmpFlag, 1'b0);
    icyc(0, 4'b0000, 4'b0000, 4'b0000, 0);
    chk("R3 change sets flag", cmpFlag, 1'b1);
    chk("R9 no irq when disabled", irqReq, 1'b0);
    icyc(0, 4'b0000, 4'b0000, 4'b0010, 0);
    chk("R8 write zero clears", cmpFlag, 1'b0);
    icyc(0, 4'b0000, 4'b0000, 4'b0000, 0);
    icyc(0, 4'b0000, 4'b0000, 4'b0000, 0);
    chk("R4 persistent mismatch", cmpFlag, 1'b0);
    icyc(1, 4'b0000, 4'b0000, 4'b0000, 0);
    chk("R5 return without read", cmpFlag, 1'b0);
    icyc(0, 4'b0000, 4'b0000, 4'b0000, 0);
    chk("R3 second change", cmpFlag, 1'b1);
    icyc(0, 4'b0010, 4'b0000, 4'b0000, 0);
    icyc(0, 4'b0000, 4'b0000, 4'b0010, 0);
    chk("R8 clear after read", cmpFlag, 1'b0);
    icyc(1, 4'b0000, 4'b0000, 4'b0000, 0);
    chk("R6 return after read", cmpFlag, 1'b1);
    icyc(1, 4'b0000, 4'b0010, 4'b0000, 0);
    icyc(1, 4'b0000, 4'b0000, 4'b0010, 0);
    chk("R8 clear before write test", cmpFlag, 1'b0);
    icyc(0, 4'b0000, 4'b0000, 4'b0000, 0);
    chk("R7 write refreshed reference", cmpFlag, 1'b1);
    icyc(0, 4'b0000, 4'b0000, 4'b0010, 0);
    icyc(0, 4'b1101, 4'b1101, 4'b0000, 0);
    icyc(1, 4'b0000, 4'b0000, 4'b0000, 0);
    chk("R2 off-slot access ignored", cmpFlag, 1'b0);
    icyc(1, 4'b0000, 4'b0000, 4'b0010, 1);
    chk("R8 write one sets", cmpFlag, 1'b1);
    icyc(1, 4'b0000, 4'b0000, 4'b1101, 0);
    chk("R2 off-slot flag write ignored", cmpFlag, 1'b1);
    icyc(0, 4'b0000, 4'b0000, 4'b0010, 0);
    chk("R8 hardware set beats clear", cmpFlag, 1'b1);
    icyc(0, 4'b0010, 4'b0000, 4'b0000, 0);
    icyc(0, 4'b0000, 4'b0000, 4'b0010, 0);
    icyc(1, 4'b0010, 4'b0000, 4'b0000, 0);
    chk("R10 read wins race", cmpFlag, 1'b0);
    icyc(1, 4'b0000, 4'b0000, 4'b0000, 0);
    chk("R10 no later set", cmpFlag, 1'b0);
    for (int e = 0; e < 8; e++) begin
      {cmpIe, periphIe, globalIe} = 3'(e);
      #0.5;
      chk("R9 gate with flag clear", irqReq, 1'b0);
    end
    icyc(1, 4'b0000, 4'b0000, 4'b0010, 1);
    for (int e = 0; e < 8; e++) begin
      {cmpIe, periphIe, globalIe} = 3'(e);
      #0.5;
      chk("R9 gate with flag set", irqReq, (e == 7) ? 1'b1 : 1'b0);
    end
    @(negedge clk);
    chk("R9 flag kept", cmpFlag, 1'b1);

    // Pseudo-random sweep checked every clock against the model
    lf = 16'hACE1;
    sweepOn = 1;
    for (int n = 0; n < 4000; n++) begin
      chk("R3/R6/R8 sweep flag", cmpFlag, mFlag);
      chk("R9 sweep irq", irqReq, mFlag & cmpIe & periphIe & globalIe);
      lf = lfsrNext(lf);
      if (lf[2:0] == 3'd0) cmpOut = ~cmpOut;
      ctrlRead  = (lf[5:3] == 3'd1);
      ctrlWrite = (lf[9:6] == 4'd2);
      flagWrite = (lf[13:10] == 4'd3);
      flagWdata = lf[14];
      if (lf[15:11] == 5'd7) {cmpIe, periphIe, globalIe} = lf[2:0] | 3'b011;
      if (lf[15:11] == 5'd9) {cmpIe, periphIe, globalIe} = 3'b111;
      @(negedge clk);
    end
    done = 1;
    summary();
    $finish;
  end
endmodule